// File: doc/BRIEF.md
# Fixed-Point Lorenz-Type State Generator

This block advances a three-variable chaotic system of the Lorenz family in signed fixed-point arithmetic. The state (x, y, z) is held in three digital integrators. Each integrator is an accumulator register that holds the value of the previous sample and adds the scaled derivative on each update. The derivatives are built from subtractions, constant gains and two cross products. The system uses the modified gains 9, 35, 20, 5 and 1.5. Every accepted step pulse produces one new triple by forward Euler integration with step 2^-8, and a one-cycle valid strobe marks it.

A host first loads a seed triple, because different seeds must give different trajectories. It then pulses the step input whenever it wants the next sample. Downstream logic, such as a bit quantizer or a keystream combiner, reads the three state words on the cycle the strobe is high. A step takes two cycles. It splits into a product stage and a commit stage, and requests that arrive during the commit cycle are dropped.

Top module: `lorenz_core`

## Requirements
- R1: After reset the outputs hold the default seeds x = 0x010000 (1.0), y = 0x008000 (0.5), z = 0x020000 (2.0) in signed Q8.16 (24 bits, 16 fraction bits), and valid_o is low.
- R2: When the block is idle and seed_load is high at a clock edge, the three seed inputs appear on the outputs after that edge and valid_o stays low. If step_en is also high in that cycle, seed_load wins and no step starts.
- R3: A step sets x' = sat(x + ((d + 128) >>> 8)), where d = 9*(y - x) and all values are raw Q8.16 integers.
- R4: A step sets y' = sat(y + ((d + 128) >>> 8)), where d = 35*x - y - 20*P, and P is the rounded product of x and z.
- R5: A step sets z' = sat(z + ((d + 128) >>> 8)), where d = 5*Q - (z + (z >>> 1)), and Q is the rounded product of x and y.
- R6: Each product is taken as (a*b + 2^15) >>> 16 and then clamped to the range -2^23 .. 2^23-1.
- R7: sat() clamps each new state to the range -2^23 .. 2^23-1, which is 0x800000 .. 0x7FFFFF.
- R8: If step_en is sampled high while the block is idle, the new triple and a single-cycle valid_o pulse appear two edges later. valid_o is low in the cycle in between.
- R9: step_en and seed_load that are sampled during the commit cycle of a step are ignored. With step_en held high, the block produces one new triple every two cycles.
- R10: In any cycle with no accepted step or load, the outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| step_en | input | 1 | Request for one integration step |
| seed_load | input | 1 | Copies the seed inputs into the state |
| seed_x | input | 24 | Seed for x, signed Q8.16 |
| seed_y | input | 24 | Seed for y, signed Q8.16 |
| seed_z | input | 24 | Seed for z, signed Q8.16 |
| x_o | output | 24 | State x, signed Q8.16 |
| y_o | output | 24 | State y, signed Q8.16 |
| z_o | output | 24 | State z, signed Q8.16 |
| valid_o | output | 1 | One-cycle strobe when a new triple is committed |

## Verification
The update is tried from the default seeds, from a loaded mixed-sign seed, and over a long free run with step_en held high. Every committed triple is compared with a bench model of the Euler equations, which separates errors in each derivative term, in the rounding and in the pacing. Seeds near full scale drive the y state into both rails and overflow the x*z product, which separates the product clamp from the state clamp. Loads and steps issued in the commit cycle, and a load and a step in the same idle cycle, show which request wins and what is dropped.

// File: rtl/lorenz_pkg.sv
package lorenz_pkg;

  typedef enum logic {
    PH_IDLE   = 1'b0,
    PH_COMMIT = 1'b1
  } phase_e;

  // Clamp a wide signed value into a w-bit two's complement range.
  function automatic longint clamp_signed(input longint v, input int unsigned w);
    longint hi;
    longint lo;
    hi = (longint'(1) <<< (w - 1)) - longint'(1);
    lo = -(longint'(1) <<< (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // Arithmetic right shift with round-half-up.
  function automatic longint round_shr(input longint v, input int unsigned sh);
    if (sh == 0) return v;
    return (v + (longint'(1) <<< (sh - 1))) >>> sh;
  endfunction

endpackage

// File: rtl/lz_product_stage.sv
module lz_product_stage #(
  parameter int ST_W   = 24,
  parameter int FRAC_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cap_en,
  input  logic signed [ST_W-1:0] x_i,
  input  logic signed [ST_W-1:0] y_i,
  input  logic signed [ST_W-1:0] z_i,
  output logic signed [ST_W-1:0] pxy_o,
  output logic signed [ST_W-1:0] pxz_o
);
  import lorenz_pkg::*;

  logic signed [ST_W-1:0] pxy_d;
  logic signed [ST_W-1:0] pxz_d;
  logic signed [ST_W-1:0] pxy_q;
  logic signed [ST_W-1:0] pxz_q;

  always_comb begin
    pxy_d = pxy_q;
    pxz_d = pxz_q;
    if (cap_en) begin
      pxy_d = ST_W'(clamp_signed(round_shr(longint'(x_i) * longint'(y_i), FRAC_W), ST_W));
      pxz_d = ST_W'(clamp_signed(round_shr(longint'(x_i) * longint'(z_i), FRAC_W), ST_W));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pxy_q <= '0;
      pxz_q <= '0;
    end else begin
      pxy_q <= pxy_d;
      pxz_q <= pxz_d;
    end
  end

  assign pxy_o = pxy_q;
  assign pxz_o = pxz_q;

endmodule

// File: rtl/lz_derivative.sv
module lz_derivative #(
  parameter int ST_W  = 24,
  parameter int D_W   = 32,
  parameter int K_SIG = 9,
  parameter int K_RHO = 35,
  parameter int K_XZ  = 20,
  parameter int K_XY  = 5
) (
  input  logic signed [ST_W-1:0] x_i,
  input  logic signed [ST_W-1:0] y_i,
  input  logic signed [ST_W-1:0] z_i,
  input  logic signed [ST_W-1:0] pxy_i,
  input  logic signed [ST_W-1:0] pxz_i,
  output logic signed [D_W-1:0]  dx_o,
  output logic signed [D_W-1:0]  dy_o,
  output logic signed [D_W-1:0]  dz_o
);

  longint xl;
  longint yl;
  longint zl;
  longint damp_z;

  always_comb begin
    xl     = longint'(x_i);
    yl     = longint'(y_i);
    zl     = longint'(z_i);
    // 1.5 * z as z plus half of z (floor)
    damp_z = zl + (zl >>> 1);
    dx_o   = D_W'(longint'(K_SIG) * (yl - xl));
    dy_o   = D_W'(longint'(K_RHO) * xl - yl - longint'(K_XZ) * longint'(pxz_i));
    dz_o   = D_W'(longint'(K_XY) * longint'(pxy_i) - damp_z);
  end

endmodule

// File: rtl/lz_integrator.sv
module lz_integrator #(
  parameter int                    ST_W    = 24,
  parameter int                    D_W     = 32,
  parameter int                    STEP_SH = 8,
  parameter logic signed [ST_W-1:0] INIT   = '0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_en,
  input  logic signed [ST_W-1:0] load_val,
  input  logic                   upd_en,
  input  logic signed [D_W-1:0]  deriv_i,
  output logic signed [ST_W-1:0] state_o
);
  import lorenz_pkg::*;

  logic signed [ST_W-1:0] acc_q;
  logic signed [ST_W-1:0] acc_d;
  longint                 incr;

  always_comb begin
    incr  = round_shr(longint'(deriv_i), STEP_SH);
    acc_d = acc_q;
    if (load_en) begin
      acc_d = load_val;
    end else if (upd_en) begin
      acc_d = ST_W'(clamp_signed(longint'(acc_q) + incr, ST_W));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= INIT;
    end else begin
      acc_q <= acc_d;
    end
  end

  assign state_o = acc_q;

endmodule

// File: rtl/lorenz_core.sv
module lorenz_core #(
  parameter int                     ST_W    = 24,
  parameter int                     FRAC_W  = 16,
  parameter int                     STEP_SH = 8,
  parameter logic signed [ST_W-1:0] INIT_X  = 24'sh010000,
  parameter logic signed [ST_W-1:0] INIT_Y  = 24'sh008000,
  parameter logic signed [ST_W-1:0] INIT_Z  = 24'sh020000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   step_en,
  input  logic                   seed_load,
  input  logic signed [ST_W-1:0] seed_x,
  input  logic signed [ST_W-1:0] seed_y,
  input  logic signed [ST_W-1:0] seed_z,
  output logic signed [ST_W-1:0] x_o,
  output logic signed [ST_W-1:0] y_o,
  output logic signed [ST_W-1:0] z_o,
  output logic                   valid_o
);
  import lorenz_pkg::*;

  localparam int D_W  = ST_W + 8;
  localparam int N_AX = 3;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  // step control
  phase_e phase_q;
  phase_e phase_d;
  logic   valid_q;
  logic   load_take;
  logic   step_take;
  logic   commit;

  assign load_take = seed_load && (phase_q == PH_IDLE);
  assign step_take = step_en && !seed_load && (phase_q == PH_IDLE);
  assign commit    = (phase_q == PH_COMMIT);

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE:   if (step_take) phase_d = PH_COMMIT;
      PH_COMMIT: phase_d = PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      phase_q <= PH_IDLE;
      valid_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      valid_q <= commit;
    end
  end

  // datapath
  logic signed [ST_W-1:0] st_q   [N_AX];
  logic signed [ST_W-1:0] seed_v [N_AX];
  logic signed [D_W-1:0]  deriv  [N_AX];
  logic signed [ST_W-1:0] pxy;
  logic signed [ST_W-1:0] pxz;

  assign seed_v[0] = seed_x;
  assign seed_v[1] = seed_y;
  assign seed_v[2] = seed_z;

  lz_product_stage #(
    .ST_W   (ST_W),
    .FRAC_W (FRAC_W)
  ) u_prod (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .cap_en (step_take),
    .x_i    (st_q[0]),
    .y_i    (st_q[1]),
    .z_i    (st_q[2]),
    .pxy_o  (pxy),
    .pxz_o  (pxz)
  );

  lz_derivative #(
    .ST_W (ST_W),
    .D_W  (D_W)
  ) u_deriv (
    .x_i   (st_q[0]),
    .y_i   (st_q[1]),
    .z_i   (st_q[2]),
    .pxy_i (pxy),
    .pxz_i (pxz),
    .dx_o  (deriv[0]),
    .dy_o  (deriv[1]),
    .dz_o  (deriv[2])
  );

  for (genvar i = 0; i < N_AX; i++) begin : g_axis
    localparam logic signed [ST_W-1:0] AX_INIT =
      (i == 0) ? INIT_X : ((i == 1) ? INIT_Y : INIT_Z);
    lz_integrator #(
      .ST_W    (ST_W),
      .D_W     (D_W),
      .STEP_SH (STEP_SH),
      .INIT    (AX_INIT)
    ) u_int (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .load_en  (load_take),
      .load_val (seed_v[i]),
      .upd_en   (commit),
      .deriv_i  (deriv[i]),
      .state_o  (st_q[i])
    );
  end

  assign x_o     = st_q[0];
  assign y_o     = st_q[1];
  assign z_o     = st_q[2];
  assign valid_o = valid_q;

endmodule

// File: rtl/lorenz_core_chk.sv
module lorenz_core_chk #(
  parameter int ST_W = 24
) (
  input logic                   clk,
  input logic                   rst_sync_n,
  input logic                   step_en,
  input logic                   seed_load,
  input logic signed [ST_W-1:0] seed_x,
  input logic signed [ST_W-1:0] seed_y,
  input logic signed [ST_W-1:0] seed_z,
  input logic signed [ST_W-1:0] x_o,
  input logic signed [ST_W-1:0] y_o,
  input logic signed [ST_W-1:0] z_o,
  input logic                   valid_o,
  input lorenz_pkg::phase_e     phase_q
);
  import lorenz_pkg::*;

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (seed_load && phase_q == PH_IDLE) |=>
      (x_o == $past(seed_x) && y_o == $past(seed_y) && z_o == $past(seed_z) && !valid_o));

  p_step_valid_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step_en && !seed_load && phase_q == PH_IDLE) |-> ##2 valid_o);

  p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    valid_o |=> !valid_o);

  p_valid_source_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    valid_o |-> $past(phase_q == PH_COMMIT));

  p_commit_drop_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase_q == PH_COMMIT) |=> (phase_q == PH_IDLE));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase_q == PH_IDLE && !seed_load) |=> ($stable(x_o) && $stable(y_o) && $stable(z_o)));

endmodule

bind lorenz_core lorenz_core_chk #(.ST_W(ST_W)) u_chk (.*);

// File: tb/lorenz_core_tb.sv
module lorenz_core_tb;

  localparam int W = 24;
  localparam longint VMAX = 64'sd8388607;
  localparam longint VMIN = -64'sd8388608;

  logic                clk;
  logic                rst_n;
  logic                step_en;
  logic                seed_load;
  logic signed [W-1:0] seed_x;
  logic signed [W-1:0] seed_y;
  logic signed [W-1:0] seed_z;
  logic signed [W-1:0] x_o;
  logic signed [W-1:0] y_o;
  logic signed [W-1:0] z_o;
  logic                valid_o;

  int n_chk  = 0;
  int n_fail = 0;
  longint ex, ey, ez;

  lorenz_core u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (step_en),
    .seed_load (seed_load),
    .seed_x    (seed_x),
    .seed_y    (seed_y),
    .seed_z    (seed_z),
    .x_o       (x_o),
    .y_o       (y_o),
    .z_o       (z_o),
    .valid_o   (valid_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // ---------------- reference model ----------------
  function automatic longint m_clamp(input longint v);
    if (v > VMAX) return VMAX;
    if (v < VMIN) return VMIN;
    return v;
  endfunction

  function automatic longint m_prod(input longint a, input longint b);
    return m_clamp((a * b + 64'sd32768) >>> 16);
  endfunction

  function automatic longint m_adv(input longint s, input longint d);
    return m_clamp(s + ((d + 64'sd128) >>> 8));
  endfunction

  task automatic model_step();
    longint p, q, dx, dy, dz;
    p  = m_prod(ex, ez);
    q  = m_prod(ex, ey);
    dx = 9 * (ey - ex);
    dy = 35 * ex - ey - 20 * p;
    dz = 5 * q - (ez + (ez >>> 1));
    ex = m_adv(ex, dx);
    ey = m_adv(ey, dy);
    ez = m_adv(ez, dz);
  endtask

  // ---------------- checking ----------------
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk(longint'(x_o) == ex, {req, " x"}, longint'(x_o), ex);
    chk(longint'(y_o) == ey, {req, " y"}, longint'(y_o), ey);
    chk(longint'(z_o) == ez, {req, " z"}, longint'(z_o), ez);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    ex = 64'sd65536; ey = 64'sd32768; ez = 64'sd131072;
    chk_state("R1 reset seeds");
    chk(valid_o == 1'b0, "R1 valid low", longint'(valid_o), 0);
  endtask

  task automatic t_load(input longint sx, input longint sy, input longint sz);
    @(negedge clk);
    seed_x = W'(sx); seed_y = W'(sy); seed_z = W'(sz);
    seed_load = 1'b1;
    @(negedge clk);
    seed_load = 1'b0;
    ex = sx; ey = sy; ez = sz;
    chk_state("R2 load");
    chk(valid_o == 1'b0, "R2 no valid on load", longint'(valid_o), 0);
  endtask

  task automatic t_step(input string req);
    @(negedge clk);
    step_en = 1'b1;
    @(negedge clk);
    step_en = 1'b0;
    chk(valid_o == 1'b0, "R8 valid low mid-step", longint'(valid_o), 0);
    chk_state("R10 held before commit");
    model_step();
    @(negedge clk);
    chk(valid_o == 1'b1, "R8 valid at commit", longint'(valid_o), 1);
    chk_state(req);
    @(negedge clk);
    chk(valid_o == 1'b0, "R8 valid single cycle", longint'(valid_o), 0);
    chk_state("R10 held after commit");
  endtask

  task automatic t_free_run();
    int pulses = 0;
    @(negedge clk);
    step_en = 1'b1;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (valid_o) begin
        pulses++;
        model_step();
        chk_state("R3 R4 R5 free run");
      end
    end
    step_en = 1'b0;
    chk(pulses == 20, "R9 one triple per two cycles", pulses, 20);
  endtask

  task automatic t_busy_ignore();
    @(negedge clk);
    step_en = 1'b1;
    @(negedge clk);
    seed_x = 24'sh111111; seed_y = 24'sh222222; seed_z = 24'sh033333;
    seed_load = 1'b1;
    model_step();
    @(negedge clk);
    step_en = 1'b0;
    seed_load = 1'b0;
    chk(valid_o == 1'b1, "R9 commit happened", longint'(valid_o), 1);
    chk_state("R9 load ignored in commit");
    @(negedge clk);
    chk(valid_o == 1'b0, "R9 step ignored in commit", longint'(valid_o), 0);
    chk_state("R9 no extra step");
  endtask

  task automatic t_load_priority();
    @(negedge clk);
    seed_x = -24'sh018000; seed_y = 24'sh00C000; seed_z = 24'sh050000;
    seed_load = 1'b1;
    step_en = 1'b1;
    @(negedge clk);
    seed_load = 1'b0;
    step_en = 1'b0;
    ex = -64'sh018000; ey = 64'sh00C000; ez = 64'sh050000;
    chk_state("R2 load wins");
    @(negedge clk);
    chk(valid_o == 1'b0, "R2 no step with load", longint'(valid_o), 0);
    @(negedge clk);
    chk(valid_o == 1'b0, "R2 no step with load late", longint'(valid_o), 0);
    chk_state("R2 state still seed");
  endtask

  task automatic t_saturation();
    t_load(64'sd8323072, 64'sd8323072, 64'sd0);
    t_step("R7 step high");
    chk(longint'(y_o) == VMAX, "R7 positive rail", longint'(y_o), VMAX);
    t_load(-64'sd8323072, -64'sd8323072, 64'sd0);
    t_step("R7 step low");
    chk(longint'(y_o) == VMIN, "R7 negative rail", longint'(y_o), VMIN);
    // x*z = -256.0 overflows and is clamped to -128.0
    t_load(64'sd1048576, 64'sd0, -64'sd1048576);
    t_step("R6 product clamp");
    chk(longint'(y_o) == 64'sd798720, "R6 y with clamped product", longint'(y_o), 64'sd798720);
  endtask

  // ---------------- sequence ----------------
  initial begin
    rst_n = 1'b0; step_en = 1'b0; seed_load = 1'b0;
    seed_x = '0; seed_y = '0; seed_z = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_step("R3 R4 R5 from reset seeds");
    t_step("R3 R4 R5 second step");
    t_load(64'sh020000, -64'sh010000, 64'sh030000);
    t_step("R3 R4 R5 loaded seed");
    t_free_run();
    t_busy_ignore();
    t_load_priority();
    t_step("R3 R4 R5 after priority");
    t_saturation();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

endmodule